// File: doc/BRIEF.md
# CPU Interrupt and Reset Sequencer

This block is the control unit of an 8-bit CPU core that takes over the bus whenever the core must be started, interrupted or held still. It watches four pins: the active-low reset, the maskable request, the edge-triggered non-maskable request and the set-overflow pin. It also takes the ready input that stalls the core. At an instruction boundary, which the core marks with its opcode-fetch indication, the block can replace normal execution with a service sequence. That sequence pushes the return address and the status byte onto the stack page, sets the interrupt-disable flag and fetches a 16-bit vector.

A reset is accepted only after the reset pin has been low for a minimum number of cycles. While the pin is low, every write is blocked. Releasing the pin starts a fixed initialisation wait, followed by a vector fetch. Ready stalls only read cycles, so writes that are already under way still finish. The core owns the stack pointer and the status register. The block reads them and tells the core, through strobes, when to decrement, store, load and set flags.

Top module: `intseq_ctrl`

## Requirements
- R1: While `res_n_i` is low, `rw_n_o` is 1 and `push_o` is 0, whatever the core asks for.
- R2: If `res_n_i` is low for at least 2 consecutive clock edges and then sampled high, the step becomes INIT for 6 cycles. Then come VEC_LO at address FFFC with `set_i_o` and `pc_lo_ld_o` high, then VEC_HI at FFFD with `pc_hi_ld_o` high, then IDLE. A low pulse that spans only one edge does not change the step.
- R3: With `irq_n_i` low and `iflag_i` clear on an edge where `sync_i` is high and the block is IDLE and not stalled, the service sequence starts and its vector is FFFE/FFFF. With `iflag_i` set, the step stays IDLE.
- R4: A service runs PUSH_H, PUSH_L, PUSH_P, one cycle each, as write cycles (`rw_n_o`=0). During these cycles `addr_o` = {8'h01, `sp_i`} and `sp_dec_o` is high. `push_o` is 3'b100 for the PC high byte, 3'b010 for the PC low byte and 3'b001 for the status byte.
- R5: A 1-to-0 transition of `nmi_n_i` is latched. At the next boundary it is serviced regardless of `iflag_i`, with vector FFFA/FFFB. One edge gives exactly one service, even if the pin stays low.
- R6: Priority is reset first, then the non-maskable request, then the maskable request. A completed reset hold overrides a running service.
- R7: A 1-to-0 transition of `so_n_i` gives a one-cycle `set_v_o` pulse in the cycle after the edge that sampled it.
- R8: `stall_o` is high when `rdy_i` was low at the previous edge and the current cycle is a read. Write cycles are never stalled. While stalled, the step does not advance and no boundary is taken.
- R9: `step_o` is one-hot: bit 0 IDLE, 1 HOLD, 2 INIT, 3 PUSH_H, 4 PUSH_L, 5 PUSH_P, 6 VEC_LO, 7 VEC_HI.
- R10: A non-maskable edge that arrives while the block is stalled stays pending and is serviced at the first unstalled boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset of the block's flops, active low |
| res_n_i | input | 1 | CPU reset pin, active low |
| irq_n_i | input | 1 | Maskable request, level, active low |
| nmi_n_i | input | 1 | Non-maskable request, falling edge |
| so_n_i | input | 1 | Set-overflow pin, falling edge |
| rdy_i | input | 1 | Ready; low stalls read cycles |
| sync_i | input | 1 | Core is in an opcode-fetch cycle (instruction boundary) |
| core_rw_n_i | input | 1 | Core's direction request in IDLE: 1 read, 0 write |
| iflag_i | input | 1 | Current interrupt-disable flag |
| sp_i | input | 8 | Current stack pointer |
| step_o | output | 8 | One-hot sequence step |
| addr_o | output | 16 | Stack or vector address during a sequence, 0 otherwise |
| rw_n_o | output | 1 | Bus direction: 1 read, 0 write |
| push_o | output | 3 | Push strobes: PC high, PC low, status |
| sp_dec_o | output | 1 | Decrement the stack pointer at this edge |
| pc_lo_ld_o | output | 1 | Load PC low byte from the data bus |
| pc_hi_ld_o | output | 1 | Load PC high byte from the data bus |
| set_i_o | output | 1 | Set the interrupt-disable flag |
| set_v_o | output | 1 | Set the overflow flag |
| stall_o | output | 1 | Core is halted this cycle |

## Verification
A ready stall and a non-maskable edge can land in the same cycle. In that cycle an opcode fetch is also held with the maskable flag set. The bench drops ready, moves to a read, and then drives the falling edge and the boundary indication together. It checks that the step stays IDLE while the stall lasts, that the latched request survives until ready returns, and that the first unstalled boundary runs the FFFA service. A second case drops ready in the middle of a service: the pushes must go through and the vector read must freeze with its load strobes low.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

    typedef enum logic [7:0] {
        ST_IDLE   = 8'h01,
        ST_HOLD   = 8'h02,
        ST_INIT   = 8'h04,
        ST_PUSH_H = 8'h08,
        ST_PUSH_L = 8'h10,
        ST_PUSH_P = 8'h20,
        ST_VEC_LO = 8'h40,
        ST_VEC_HI = 8'h80
    } step_e;

    typedef enum logic [1:0] {
        SRC_RES = 2'd0,
        SRC_NMI = 2'd1,
        SRC_IRQ = 2'd2
    } src_e;

    localparam logic [15:0] VEC_NMI_LO = 16'hFFFA;
    localparam logic [15:0] VEC_RES_LO = 16'hFFFC;
    localparam logic [15:0] VEC_IRQ_LO = 16'hFFFE;
    localparam logic [7:0]  STACK_PAGE = 8'h01;

    function automatic logic [15:0] vec_base(input src_e s);
        case (s)
            SRC_NMI: vec_base = VEC_NMI_LO;
            SRC_IRQ: vec_base = VEC_IRQ_LO;
            default: vec_base = VEC_RES_LO;
        endcase
    endfunction

endpackage

// File: rtl/res_watch.sv
module res_watch #(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic res_n_i,
    output logic start_o,
    output logic hold_o
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_LOW);
    localparam logic [CW-1:0] CNT_HOLD = CW'(MIN_LOW - 1);

    typedef struct packed {
        logic          res;
        logic [CW-1:0] cnt;
    } rw_t;

    rw_t d, q;

    always_comb begin
        d     = q;
        d.res = res_n_i;
        if (res_n_i)
            d.cnt = '0;
        else if (q.cnt != CNT_MAX)
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_o = res_n_i & ~q.res & (q.cnt == CNT_MAX);
    assign hold_o  = ~res_n_i & (q.cnt >= CNT_HOLD);

    // R2
    res_start_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (q.cnt == '0) && q.res);

endmodule

// File: rtl/pin_edges.sv
module pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n_i,
    input  logic so_n_i,
    input  logic nmi_clr_i,
    output logic nmi_pend_o,
    output logic set_v_o
);
    typedef struct packed {
        logic nmi;
        logic so;
        logic pend;
        logic setv;
    } pe_t;

    pe_t d, q;

    always_comb begin
        d      = q;
        d.nmi  = nmi_n_i;
        d.so   = so_n_i;
        d.pend = (q.pend & ~nmi_clr_i) | (q.nmi & ~nmi_n_i);
        d.setv = q.so & ~so_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{nmi: 1'b1, so: 1'b1, pend: 1'b0, setv: 1'b0};
        else        q <= d;
    end

    assign nmi_pend_o = q.pend;
    assign set_v_o    = q.setv;

    // R5
    nmi_edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.nmi && !nmi_n_i) |=> nmi_pend_o);

    // R7
    so_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(so_n_i) |=> set_v_o);

endmodule

// File: rtl/intseq_ctrl.sv
module intseq_ctrl
    import intseq_pkg::*;
#(
    parameter int INIT_CYCLES = 6,
    parameter int MIN_RES_LOW = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        res_n_i,
    input  logic        irq_n_i,
    input  logic        nmi_n_i,
    input  logic        so_n_i,
    input  logic        rdy_i,
    input  logic        sync_i,
    input  logic        core_rw_n_i,
    input  logic        iflag_i,
    input  logic [7:0]  sp_i,
    output logic [7:0]  step_o,
    output logic [15:0] addr_o,
    output logic        rw_n_o,
    output logic [2:0]  push_o,
    output logic        sp_dec_o,
    output logic        pc_lo_ld_o,
    output logic        pc_hi_ld_o,
    output logic        set_i_o,
    output logic        set_v_o,
    output logic        stall_o
);
    localparam int CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    typedef struct packed {
        step_e            state;
        logic [CNT_W-1:0] cnt;
        src_e             src;
        logic             rdy;
    } seq_t;

    seq_t d, q;

    logic res_start, res_hold;
    logic nmi_pend, nmi_clr;
    logic rd_cycle, stall;

    res_watch #(.MIN_LOW(MIN_RES_LOW)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .res_n_i (res_n_i),
        .start_o (res_start),
        .hold_o  (res_hold)
    );

    pin_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_n_i    (nmi_n_i),
        .so_n_i     (so_n_i),
        .nmi_clr_i  (nmi_clr),
        .nmi_pend_o (nmi_pend),
        .set_v_o    (set_v_o)
    );

    always_comb begin
        case (q.state)
            ST_IDLE:                         rd_cycle = core_rw_n_i;
            ST_PUSH_H, ST_PUSH_L, ST_PUSH_P: rd_cycle = 1'b0;
            default:                         rd_cycle = 1'b1;
        endcase
    end

    assign stall = ~q.rdy & rd_cycle;

    always_comb begin
        d       = q;
        d.rdy   = rdy_i;
        nmi_clr = 1'b0;
        if (res_start) begin
            d.state = ST_INIT;
            d.cnt   = '0;
            d.src   = SRC_RES;
            nmi_clr = 1'b1;
        end else if (res_hold) begin
            d.state = ST_HOLD;
        end else if (!stall) begin
            case (q.state)
                ST_IDLE: begin
                    if (sync_i && nmi_pend) begin
                        d.state = ST_PUSH_H;
                        d.src   = SRC_NMI;
                        nmi_clr = 1'b1;
                    end else if (sync_i && !irq_n_i && !iflag_i) begin
                        d.state = ST_PUSH_H;
                        d.src   = SRC_IRQ;
                    end
                end
                ST_INIT: begin
                    if (q.cnt == CNT_LAST) d.state = ST_VEC_LO;
                    else                   d.cnt   = q.cnt + 1'b1;
                end
                ST_PUSH_H: d.state = ST_PUSH_L;
                ST_PUSH_L: d.state = ST_PUSH_P;
                ST_PUSH_P: d.state = ST_VEC_LO;
                ST_VEC_LO: d.state = ST_VEC_HI;
                ST_VEC_HI: d.state = ST_IDLE;
                default:   d.state = q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_HOLD, cnt: '0, src: SRC_RES, rdy: 1'b1};
        else        q <= d;
    end

    always_comb begin
        case (q.state)
            ST_PUSH_H, ST_PUSH_L, ST_PUSH_P: addr_o = {STACK_PAGE, sp_i};
            ST_VEC_LO:                       addr_o = vec_base(q.src);
            ST_VEC_HI:                       addr_o = vec_base(q.src) | 16'h0001;
            default:                         addr_o = '0;
        endcase
    end

    assign step_o     = q.state;
    assign stall_o    = stall;
    assign rw_n_o     = ~res_n_i | rd_cycle;
    assign push_o     = {3{res_n_i}} & {q.state == ST_PUSH_H, q.state == ST_PUSH_L,
                                        q.state == ST_PUSH_P};
    assign sp_dec_o   = |push_o;
    assign pc_lo_ld_o = (q.state == ST_VEC_LO) & ~stall;
    assign pc_hi_ld_o = (q.state == ST_VEC_HI) & ~stall;
    assign set_i_o    = pc_lo_ld_o;

    // R1
    res_low_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_n_i |-> (rw_n_o && push_o == 3'b000));

    // R8
    stall_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> rw_n_o);

    // R8
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && res_n_i) |=> $stable(step_o));

    // R4
    push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == ST_PUSH_H && res_n_i) |=> (step_o == ST_PUSH_L));

    // R9
    onehot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_o) == 1);

    // R2
    res_enter_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_start |=> (step_o == ST_INIT));

endmodule

// File: tb/tb_intseq_ctrl.sv
module tb_intseq_ctrl;
    logic clk = 1'b0;
    logic rst_n, res_n, irq_n, nmi_n, so_n, rdy, sync, core_rw_n, iflag;
    logic [7:0]  sp;
    logic [7:0]  step;
    logic [15:0] addr;
    logic        rw_n, sp_dec, pc_lo_ld, pc_hi_ld, set_i, set_v, stall;
    logic [2:0]  push;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    intseq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .res_n_i(res_n), .irq_n_i(irq_n), .nmi_n_i(nmi_n),
        .so_n_i(so_n), .rdy_i(rdy), .sync_i(sync), .core_rw_n_i(core_rw_n),
        .iflag_i(iflag), .sp_i(sp), .step_o(step), .addr_o(addr), .rw_n_o(rw_n),
        .push_o(push), .sp_dec_o(sp_dec), .pc_lo_ld_o(pc_lo_ld), .pc_hi_ld_o(pc_hi_ld),
        .set_i_o(set_i), .set_v_o(set_v), .stall_o(stall)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // block sits in PUSH_H; walks the whole service
    task automatic run_service(input logic [15:0] vlo, input string req);
        logic [7:0] st_exp [3] = '{8'h08, 8'h10, 8'h20};
        logic [2:0] pu_exp [3] = '{3'b100, 3'b010, 3'b001};
        for (int i = 0; i < 3; i++) begin
            chk("R4", "push step", {8'h00, step}, {8'h00, st_exp[i]});
            chk("R4", "stack addr", addr, {8'h01, sp});
            chk("R4", "push write", {15'h0, rw_n}, 16'h0);
            chk("R4", "push strobe", {13'h0, push}, {13'h0, pu_exp[i]});
            chk("R4", "sp dec", {15'h0, sp_dec}, 16'h1);
            if (sp_dec) sp = sp - 1'b1;
            tick();
        end
        chk(req, "vec lo step", {8'h00, step}, 16'h0040);
        chk(req, "vec lo addr", addr, vlo);
        chk(req, "set iflag", {15'h0, set_i}, 16'h1);
        tick();
        chk(req, "vec hi addr", addr, vlo | 16'h1);
        chk(req, "pc hi load", {15'h0, pc_hi_ld}, 16'h1);
        tick();
        chk(req, "back to idle", {8'h00, step}, 16'h0001);
    endtask

    task automatic t_power_reset();
        rst_n = 1'b0; res_n = 1'b0; core_rw_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick(); tick();
        chk("R1", "rw_n while reset low", {15'h0, rw_n}, 16'h1);
        chk("R9", "hold step", {8'h00, step}, 16'h0002);
        core_rw_n = 1'b1;
        res_n = 1'b1;
        tick();
        for (int i = 0; i < 6; i++) begin
            chk("R2", "init step", {8'h00, step}, 16'h0004);
            tick();
        end
        chk("R2", "reset vec lo", addr, 16'hFFFC);
        chk("R2", "reset set iflag", {15'h0, set_i}, 16'h1);
        chk("R2", "pc lo load", {15'h0, pc_lo_ld}, 16'h1);
        tick();
        chk("R2", "reset vec hi", addr, 16'hFFFD);
        tick();
        chk("R2", "idle after reset", {8'h00, step}, 16'h0001);
    endtask

    task automatic t_short_pulse();
        core_rw_n = 1'b0;
        res_n = 1'b0;
        #1;
        chk("R1", "write blocked by reset pin", {15'h0, rw_n}, 16'h1);
        tick();
        res_n = 1'b1;
        core_rw_n = 1'b1;
        tick();
        chk("R2", "short pulse ignored", {8'h00, step}, 16'h0001);
        tick();
        chk("R2", "short pulse still idle", {8'h00, step}, 16'h0001);
    endtask

    task automatic t_irq();
        iflag = 1'b1; irq_n = 1'b0; sync = 1'b1;
        tick();
        sync = 1'b0;
        chk("R3", "masked irq stays idle", {8'h00, step}, 16'h0001);
        iflag = 1'b0; sync = 1'b1;
        tick();
        sync = 1'b0; irq_n = 1'b1;
        run_service(16'hFFFE, "R3");
    endtask

    task automatic t_nmi();
        iflag = 1'b1;
        nmi_n = 1'b0;
        tick();
        sync = 1'b1;
        tick();
        sync = 1'b0;
        run_service(16'hFFFA, "R5");
        sync = 1'b1;
        tick();
        sync = 1'b0;
        chk("R5", "one edge one service", {8'h00, step}, 16'h0001);
        nmi_n = 1'b1;
        tick();
    endtask

    task automatic t_priority();
        iflag = 1'b0; irq_n = 1'b0; nmi_n = 1'b0;
        tick();
        sync = 1'b1;
        tick();
        sync = 1'b0;
        run_service(16'hFFFA, "R6");
        sync = 1'b1;
        tick();
        sync = 1'b0;
        nmi_n = 1'b1;
        run_service(16'hFFFE, "R6");
        // reset overrides a running service
        sync = 1'b1;
        tick();
        sync = 1'b0; irq_n = 1'b1;
        res_n = 1'b0;
        #1;
        chk("R1", "push blocked by reset", {13'h0, push}, 16'h0);
        tick(); tick();
        chk("R6", "reset hold wins", {8'h00, step}, 16'h0002);
        res_n = 1'b1;
        tick();
        chk("R6", "reset restarts init", {8'h00, step}, 16'h0004);
        for (int i = 0; i < 8; i++) tick();
        chk("R6", "idle after reset", {8'h00, step}, 16'h0001);
    endtask

    task automatic t_so();
        so_n = 1'b0;
        tick();
        chk("R7", "set_v pulse", {15'h0, set_v}, 16'h1);
        tick();
        chk("R7", "set_v single", {15'h0, set_v}, 16'h0);
        so_n = 1'b1;
        tick();
        chk("R7", "set_v quiet", {15'h0, set_v}, 16'h0);
    endtask

    task automatic t_rdy_boundary();
        iflag = 1'b1;
        core_rw_n = 1'b1;
        rdy = 1'b0;
        #1;
        chk("R8", "current read completes", {15'h0, stall}, 16'h0);
        tick();
        core_rw_n = 1'b0;
        #1;
        chk("R8", "write not stalled", {15'h0, stall}, 16'h0);
        tick();
        core_rw_n = 1'b1; sync = 1'b1; nmi_n = 1'b0;
        #1;
        chk("R8", "read stalled", {15'h0, stall}, 16'h1);
        tick();
        chk("R10", "no boundary while stalled", {8'h00, step}, 16'h0001);
        chk("R10", "still stalled", {15'h0, stall}, 16'h1);
        rdy = 1'b1;
        tick();
        chk("R8", "stall released", {15'h0, stall}, 16'h0);
        chk("R10", "idle until boundary", {8'h00, step}, 16'h0001);
        tick();
        sync = 1'b0;
        run_service(16'hFFFA, "R10");
        nmi_n = 1'b1;
        tick();
    endtask

    task automatic t_rdy_seq();
        iflag = 1'b0; irq_n = 1'b0; sync = 1'b1;
        tick();
        sync = 1'b0; irq_n = 1'b1;
        rdy = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R8", "push not stalled", {15'h0, stall}, 16'h0);
            if (sp_dec) sp = sp - 1'b1;
            tick();
        end
        chk("R8", "vector read stalled", {15'h0, stall}, 16'h1);
        chk("R8", "no load while stalled", {15'h0, pc_lo_ld}, 16'h0);
        tick();
        chk("R8", "step frozen", {8'h00, step}, 16'h0040);
        rdy = 1'b1;
        tick();
        chk("R8", "resume vec lo", addr, 16'hFFFE);
        chk("R8", "resume set iflag", {15'h0, set_i}, 16'h1);
        tick(); tick();
        chk("R8", "idle after stall", {8'h00, step}, 16'h0001);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; res_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1; so_n = 1'b1;
        rdy = 1'b1; sync = 1'b0; core_rw_n = 1'b1; iflag = 1'b0; sp = 8'hFD;
        #1;
        t_power_reset();
        t_short_pulse();
        t_irq();
        t_nmi();
        t_priority();
        t_so();
        t_rdy_boundary();
        t_rdy_seq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule